// File: doc/BRIEF.md
# Multiplexed ADC serial readout controller

This controller sits on the host side of a multi-channel delta-sigma converter whose input multiplexer and output shift register share one serial clock and one select line. When a request arrives with a channel number, the controller pulls the select low and watches the converter's serial data line. The converter reports end of conversion by driving that line low. The controller then runs 24 serial clock cycles. On these clocks it shifts a four-bit multiplexer selection out and a 24-bit result word in.

The incoming word holds a conversion-pending flag, a zero filler bit, a polarity bit, an extended-range bit and a 20-bit magnitude field. The controller turns these into a 24-bit two's-complement sample and raises clamp flags for the two saturation codes. It returns the sample with the channel it was requested for, as a one-cycle valid pulse. If the converter stays busy longer than a programmable number of polls, a timeout result is issued in its place. The multiplexer select input is the inverse of `adc_cs_n` and is formed outside the block.

Top module: `adc_mux_reader`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_sclk` is 0, `req_ready` is 1 and `smp_valid` is 0.
- R2: `adc_sdo` is ignored while `adc_cs_n` is high. After a request, `adc_cs_n` goes low and `adc_sclk` stays low until a poll of `adc_sdo` reads 0. Polls are taken every `DIV_HALF` clocks.
- R3: On the first four rising edges of `adc_sclk`, `adc_din` carries 1 (enable), then channel bits 2, 1 and 0. On the remaining rising edges it carries 0.
- R4: Each transfer has exactly 24 rising `adc_sclk` edges with `adc_cs_n` low. `adc_sclk` is low whenever `adc_cs_n` is high. Between transfers, `adc_cs_n` stays high for at least 2·`DIV_HALF` clocks.
- R5: The word is received MSB first. Bit 21 is the polarity bit P, bit 20 is the extended-range bit X, and bits 19:0 are the field F. When P=1, the sample is the unsigned value {X,F} (for example, F=all ones with X=0 gives 0x0FFFFF, and X=1 with F=0 gives 0x100000).
- R6: When P=0, the sample is {X,F} − 2^21 (for example, X=1 with F=all ones gives −1).
- R7: The zero code decodes to 0 in both forms: P=1 with X=0 and F=0, and P=0 with X=0 and F=0.
- R8: `smp_ovr` is 1 only for P=1, X=1, F=0x1FFFF (sample 0x11FFFF). `smp_und` is 1 only for P=0, X=1, F=0xE0000 (sample −0x20000).
- R9: If `tmo_limit` successive polls read 1, the controller raises `adc_cs_n` with no `adc_sclk` edge. It then pulses `smp_valid` with `smp_err`=1 and a sample of 0.
- R10: When the poll that would reach `tmo_limit` reads 0, the transfer runs and `smp_err` stays 0.
- R11: `smp_valid` is a one-cycle pulse, and `smp_ch` equals the channel given with the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Controller idle, request accepted |
| req_ch | input | 3 | Multiplexer channel to read |
| tmo_limit | input | TMO_W | Busy polls before a timeout |
| adc_cs_n | output | 1 | Shared select, active low for the converter |
| adc_sclk | output | 1 | Shared serial clock |
| adc_din | output | 1 | Multiplexer selection bit stream |
| adc_sdo | input | 1 | Converter serial data, high-Z when deselected |
| smp_valid | output | 1 | Sample strobe |
| smp_value | output | 24 | Signed sample |
| smp_ovr | output | 1 | Positive clamp code received |
| smp_und | output | 1 | Negative clamp code received |
| smp_err | output | 1 | Conversion-ready timeout |
| smp_ch | output | 3 | Channel of the sample |

## Verification
Two functions can land on the same poll: the converter reporting ready, and the busy-poll count reaching its limit. The bench releases the data line between poll `tmo_limit`−1 and poll `tmo_limit`. Ready must then win: the bench expects a full 24-clock transfer and a sample without the error flag. The bench also releases the line two clocks after that last poll. In that case it expects a timeout with no clock edges.

// File: rtl/adc_mux_reader.sv
module adc_mux_reader #(
  parameter int DIV_HALF  = 4,
  parameter int TMO_W     = 16,
  parameter int GAP_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_ch,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              adc_cs_n,
  output logic              adc_sclk,
  output logic              adc_din,
  input  logic              adc_sdo,
  output logic              smp_valid,
  output logic [23:0]       smp_value,
  output logic              smp_ovr,
  output logic              smp_und,
  output logic              smp_err,
  output logic [2:0]        smp_ch
);

  localparam int WORD = 24;
  localparam int DW   = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int BW   = $clog2(WORD + 1);
  localparam logic [19:0] OVR_F = 20'h1FFFF;
  localparam logic [19:0] UND_F = 20'hE0000;

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_XFER, S_GAP} st_t;

  st_t              st;
  logic [DW-1:0]    div_q;
  logic [BW-1:0]    bits_q;
  logic [TMO_W-1:0] poll_q;
  logic [3:0]       nib_q;
  logic [21:0]      sh_q;
  logic [2:0]       ch_q;
  logic             sclk_q;

  wire tick = (div_q == DW'(DIV_HALF - 1));
  wire [TMO_W:0] poll_nxt = {1'b0, poll_q} + {{TMO_W{1'b0}}, 1'b1};
  wire tmo_hit = poll_nxt >= {1'b0, tmo_limit};

  assign req_ready = (st == S_IDLE);
  assign adc_cs_n  = !(st == S_POLL || st == S_XFER);
  assign adc_sclk  = sclk_q;
  assign adc_din   = (st == S_XFER) && nib_q[3];

  wire        w_p = sh_q[21];
  wire        w_x = sh_q[20];
  wire [19:0] w_f = sh_q[19:0];
  wire [23:0] w_mag = {3'b000, w_x, w_f};
  logic [23:0] dec;

  always_comb begin
    if (w_p)                   dec = w_mag;
    else if (!w_x && w_f == 0) dec = '0;
    else                       dec = w_mag - 24'h200000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else if (st == S_IDLE || tick) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bits_q    <= '0;
      poll_q    <= '0;
      nib_q     <= '0;
      sh_q      <= '0;
      ch_q      <= '0;
      sclk_q    <= 1'b0;
      smp_valid <= 1'b0;
      smp_value <= '0;
      smp_ovr   <= 1'b0;
      smp_und   <= 1'b0;
      smp_err   <= 1'b0;
      smp_ch    <= '0;
    end else begin
      smp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ch_q   <= req_ch;
          nib_q  <= {1'b1, req_ch};
          poll_q <= '0;
          st     <= S_POLL;
        end
        S_POLL: if (tick) begin
          if (!adc_sdo) begin
            bits_q <= '0;
            st     <= S_XFER;
          end else if (tmo_hit) begin
            smp_valid <= 1'b1;
            smp_err   <= 1'b1;
            smp_value <= '0;
            smp_ovr   <= 1'b0;
            smp_und   <= 1'b0;
            smp_ch    <= ch_q;
            bits_q    <= '0;
            st        <= S_GAP;
          end else begin
            poll_q <= poll_nxt[TMO_W-1:0];
          end
        end
        S_XFER: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            sh_q   <= {sh_q[20:0], adc_sdo};
          end else begin
            sclk_q <= 1'b0;
            nib_q  <= {nib_q[2:0], 1'b0};
            if (bits_q == BW'(WORD - 1)) begin
              smp_valid <= 1'b1;
              smp_err   <= 1'b0;
              smp_value <= dec;
              smp_ovr   <= w_p && w_x && (w_f == OVR_F);
              smp_und   <= !w_p && w_x && (w_f == UND_F);
              smp_ch    <= ch_q;
              bits_q    <= '0;
              st        <= S_GAP;
            end else begin
              bits_q <= bits_q + 1'b1;
            end
          end
        end
        default: if (tick) begin
          if (bits_q >= BW'(GAP_TICKS - 1)) st <= S_IDLE;
          else bits_q <= bits_q + 1'b1;
        end
      endcase
    end
  end

  logic       sclk_d;
  logic [5:0] rise_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      rise_q <= '0;
    end else begin
      sclk_d <= adc_sclk;
      if (adc_cs_n) rise_q <= '0;
      else if (adc_sclk && !sclk_d) rise_q <= rise_q + 1'b1;
    end
  end

  // R4
  sclk_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_sclk |-> !adc_cs_n);
  // R4
  rise_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_cs_n) |-> (rise_q == 6'd0 || rise_q == 6'd24));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (adc_cs_n && !adc_sclk));
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  // R8
  clamp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !(smp_ovr && smp_und));
  // R9
  tmo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_err) |-> (smp_value == 24'd0 && !smp_ovr && !smp_und));

endmodule

// File: tb/adc_mux_reader_bench.sv
module adc_mux_reader_bench;
  localparam int DH = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, adc_cs_n, adc_sclk, adc_din, adc_sdo;
  logic [2:0] req_ch, smp_ch;
  logic [15:0] tmo_limit;
  logic smp_valid, smp_ovr, smp_und, smp_err;
  logic [23:0] smp_value;

  adc_mux_reader u_adc_mux_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ch(req_ch), .tmo_limit(tmo_limit), .adc_cs_n(adc_cs_n),
    .adc_sclk(adc_sclk), .adc_din(adc_din), .adc_sdo(adc_sdo),
    .smp_valid(smp_valid), .smp_value(smp_value), .smp_ovr(smp_ovr),
    .smp_und(smp_und), .smp_err(smp_err), .smp_ch(smp_ch));

  int total = 0, bad = 0;
  logic [23:0] dev_word = '0;
  int ready_at = 0, cyc = 0, idx = 23;
  logic sclk_p = 1'b0, idle_low = 1'b0;
  int rises = 0, extra_din = 0, first_rise = -1, hi_run = 0, last_hi = 0;
  logic [3:0] nib = '0;
  logic [23:0] r_val;
  logic r_ovr, r_und, r_err, r_got;
  logic [2:0] r_ch;

  assign adc_sdo = adc_cs_n ? (idle_low ? 1'b0 : 1'bz)
                 : ((cyc < ready_at) ? 1'b1 : ((idx >= 0) ? dev_word[idx] : 1'b0));

  always @(posedge clk) begin
    if (adc_cs_n) begin idx <= 23; cyc <= 0; end
    else begin
      cyc <= cyc + 1;
      if (sclk_p && !adc_sclk) idx <= idx - 1;
    end
    sclk_p <= adc_sclk;
    if (!adc_cs_n && !sclk_p && adc_sclk) begin
      rises = rises + 1;
      if (rises == 1) first_rise = cyc;
      if (rises <= 4) nib = {nib[2:0], adc_din};
      else if (adc_din) extra_din = extra_din + 1;
    end
    if (adc_cs_n) hi_run = hi_run + 1;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic p, input logic x, input logic [19:0] f);
    return {2'b00, p, x, f};
  endfunction

  function automatic logic [23:0] expect_val(input logic p, input logic x, input logic [19:0] f);
    if (p) return {3'b000, x, f};
    if (!x && f == 20'd0) return 24'd0;
    return {3'b000, x, f} - 24'h200000;
  endfunction

  task automatic run(input logic [2:0] ch, input logic [23:0] w, input int rdy, input int tmo);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    dev_word = w; ready_at = rdy; tmo_limit = 16'(tmo);
    rises = 0; extra_din = 0; first_rise = -1; nib = '0;
    req_valid = 1'b1; req_ch = ch;
    @(negedge clk);
    req_valid = 1'b0;
    r_got = 1'b0;
    for (int i = 0; i < 3000 && !r_got; i++) begin
      if (smp_valid) begin
        r_got = 1'b1; r_val = smp_value; r_ovr = smp_ovr; r_und = smp_und;
        r_err = smp_err; r_ch = smp_ch;
      end else @(negedge clk);
    end
    chk("R11 result arrives", 32'(r_got), 32'd1);
    @(negedge clk);
    chk("R11 valid single cycle", 32'(smp_valid), 32'd0);
  endtask

  task automatic read_ok(input string r, input logic [2:0] ch, input logic p,
                         input logic x, input logic [19:0] f, input int rdy, input int tmo);
    run(ch, mk(p, x, f), rdy, tmo);
    chk({r, " value"}, 32'(r_val), 32'(expect_val(p, x, f)));
    chk({r, " R8 ovr"}, 32'(r_ovr), 32'(p && x && f == 20'h1FFFF));
    chk({r, " R8 und"}, 32'(r_und), 32'(!p && x && f == 20'hE0000));
    chk({r, " err"}, 32'(r_err), 32'd0);
    chk({r, " R11 channel"}, 32'(r_ch), 32'(ch));
    chk({r, " R4 rises"}, 32'(rises), 32'd24);
    chk({r, " R3 nibble"}, 32'(nib), 32'({1'b1, ch}));
    chk({r, " R3 din tail"}, 32'(extra_din), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 cs_n", 32'(adc_cs_n), 32'd1);
    chk("R1 sclk", 32'(adc_sclk), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 valid", 32'(smp_valid), 32'd0);
  endtask

  task automatic t_positive;
    read_ok("R5 half", 3'd5, 1'b1, 1'b0, 20'h80000, 0, 1000);
    read_ok("R5 full", 3'd2, 1'b1, 1'b0, 20'hFFFFF, 0, 1000);
    read_ok("R5 full+1", 3'd7, 1'b1, 1'b1, 20'h00000, 0, 1000);
  endtask

  task automatic t_negative;
    read_ok("R6 minus1", 3'd1, 1'b0, 1'b1, 20'hFFFFF, 0, 1000);
    read_ok("R6 mid", 3'd6, 1'b0, 1'b1, 20'hF0000, 0, 1000);
  endtask

  task automatic t_zero;
    read_ok("R7 zero p1", 3'd3, 1'b1, 1'b0, 20'h0, 0, 1000);
    read_ok("R7 zero p0", 3'd4, 1'b0, 1'b0, 20'h0, 0, 1000);
  endtask

  task automatic t_clamp;
    read_ok("R8 top", 3'd0, 1'b1, 1'b1, 20'h1FFFF, 0, 1000);
    chk("R8 top value", 32'(r_val), 32'h0011FFFF);
    read_ok("R8 bottom", 3'd5, 1'b0, 1'b1, 20'hE0000, 0, 1000);
    chk("R8 bottom value", 32'(r_val), 32'h00FE0000);
  endtask

  task automatic t_poll;
    idle_low = 1'b1;
    repeat (40) @(negedge clk);
    chk("R2 idle cs_n", 32'(adc_cs_n), 32'd1);
    chk("R2 idle ready", 32'(req_ready), 32'd1);
    idle_low = 1'b0;
    read_ok("R2 busy wait", 3'd2, 1'b1, 1'b0, 20'h12345, 5 * DH + 2, 1000);
    chk("R2 no sclk before ready", 32'(first_rise >= 5 * DH + 2), 32'd1);
  endtask

  task automatic t_gap;
    read_ok("R4 first", 3'd1, 1'b1, 1'b0, 20'h00001, 0, 1000);
    read_ok("R4 second", 3'd6, 1'b1, 1'b0, 20'h00002, 0, 1000);
    chk("R4 gap", 32'(last_hi >= 2 * DH), 32'd1);
  endtask

  task automatic t_timeout;
    run(3'd4, mk(1'b1, 1'b0, 20'h55555), 1000000, 3);
    chk("R9 err", 32'(r_err), 32'd1);
    chk("R9 value", 32'(r_val), 32'd0);
    chk("R9 no sclk", 32'(rises), 32'd0);
    chk("R9 channel", 32'(r_ch), 32'd4);
    chk("R9 cs_n", 32'(adc_cs_n), 32'd1);
    run(3'd3, mk(1'b1, 1'b0, 20'h55555), 3 * DH + 2, 3);
    chk("R9 late ready err", 32'(r_err), 32'd1);
    chk("R9 late ready no sclk", 32'(rises), 32'd0);
  endtask

  task automatic t_coincide;
    read_ok("R10 ready at limit", 3'd7, 1'b1, 1'b0, 20'hABCDE, 3 * DH - 2, 3);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_ch = '0; tmo_limit = 16'd1000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_positive();
    t_negative();
    t_zero();
    t_clamp();
    t_poll();
    t_gap();
    t_timeout();
    t_coincide();
    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule